// File: doc/BRIEF.md
# Frequency Test Output Controller

This block decides what a timekeeping device puts on its shared interrupt / frequency-test pin. A divider driven by the 32768 Hz oscillator tick makes a 512 Hz square wave. While the control bits select test mode, that square wave reaches the pin. In every other state the pin carries the alarm or watchdog interrupt request. The pin is open drain, so the block has only one output for it: a drive-low enable. When that enable is 1 the pin is pulled low. When it is 0 the pin is released to its pull-up.

The block holds the frequency-test enable bit itself. A write strobe loads the bit, and a power-fail input clears it. The other control bits come in as plain inputs: the oscillator stop bit, the alarm interrupt enable, and the watchdog configuration byte, whose most significant bit is the steering bit. The divider takes no calibration value, so any calibration applied elsewhere cannot change the test frequency. There is no data stream, so every pin is a plain level or strobe.

Top module: `ftc_top`

## Requirements
- R1: After reset, `pin_drive_low` is 0, `ft_bit` is 0 and the divider phase is low.
- R2: When `ft_wr_en` is 1 and `power_fail` is 0 at a clock edge, `ft_bit` takes the value of `ft_wr_val` after that edge.
- R3: `power_fail` overrides a write in the same cycle and clears `ft_bit` at the next edge. While `power_fail` is 1, `pin_drive_low` is 0.
- R4: Test mode is active, and is shown on `tone_active`, only when all of these hold: `osc_stop`=0, `ft_bit`=1, `alarm_int_en`=0, `power_fail`=0, and either bit 7 of `wdog_cfg` is 1 or all of `wdog_cfg` is zero.
- R5: In test mode, `pin_drive_low` is 1 while the divider phase is low and 0 while it is high. The phase flips once every 32 counted ticks, so the pin runs at 512 Hz from a 32768 Hz tick.
- R6: The divider counts `osc_tick` only while `osc_stop` is 0. While the oscillator is stopped, the phase is frozen.
- R7: Outside test mode, with `power_fail`=0, `pin_drive_low` is 1 exactly when (`alarm_int_en` and `alarm_flag`) are both 1, or when `wdog_timeout` is 1 with bit 7 of `wdog_cfg` at 0. Otherwise it is 0.
- R8: The divider keeps running while test mode is off. When test mode is entered, the phase continues from the number of ticks counted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per 32768 Hz oscillator period |
| osc_stop | input | 1 | Oscillator stop control bit |
| ft_wr_en | input | 1 | Write strobe for the frequency-test bit |
| ft_wr_val | input | 1 | Value written to the frequency-test bit |
| alarm_int_en | input | 1 | Alarm interrupt enable |
| alarm_flag | input | 1 | Alarm flag is set |
| wdog_cfg | input | 8 | Watchdog configuration byte; bit 7 is the steering bit |
| wdog_timeout | input | 1 | Watchdog has expired |
| power_fail | input | 1 | Supply failure indication |
| pin_drive_low | output | 1 | Open-drain enable: 1 pulls the pin low, 0 releases it |
| ft_bit | output | 1 | Current frequency-test bit |
| tone_active | output | 1 | Test mode is selected |

## Verification
The assertions check five things on every cycle. Power-fail releases the pin and clears the test bit. A stopped oscillator freezes the divider phase. The phase changes only on a counted tick. The pin follows either the phase or the interrupt routing, depending on test mode, and a write updates the test bit. The period of exactly 32 ticks per half-wave, its phase after time spent outside test mode, and the full decode of the enabling conditions and interrupt sources show up only in the bench scenarios. Those scenarios keep their own tick count and compare the pin against it.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int unsigned TONE_HALF_DEF = 32;  // ticks per half period: 32768/(2*512)
  localparam int unsigned WDOG_W_DEF    = 8;

  typedef struct packed {
    logic osc_run;
    logic ft_on;
    logic alarm_quiet;
    logic wdog_ok;
    logic supply_ok;
  } ftc_qual_t;

  function automatic logic qual_all(input ftc_qual_t q);
    return q.osc_run & q.ft_on & q.alarm_quiet & q.wdog_ok & q.supply_ok;
  endfunction
endpackage

// File: rtl/ftc_tone_div.sv
module ftc_tone_div #(
  parameter int unsigned TONE_HALF = ftc_pkg::TONE_HALF_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic sq
);
  localparam int unsigned CNT_W = (TONE_HALF > 1) ? $clog2(TONE_HALF) : 1;

  logic sq_q;

  generate
    if (TONE_HALF > 1) begin : g_count
      logic [CNT_W-1:0] cnt_q;
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TONE_HALF - 1);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
          sq_q  <= 1'b0;
        end else if (tick_en) begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            sq_q  <= ~sq_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (!rst_n)       sq_q <= 1'b0;
        else if (tick_en) sq_q <= ~sq_q;
      end
    end
  endgenerate

  assign sq = sq_q;
endmodule

// File: rtl/ftc_ft_reg.sv
module ftc_ft_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic power_fail,
  output logic ft_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)          ft_q <= 1'b0;
    else if (power_fail) ft_q <= 1'b0;
    else if (wr_en)      ft_q <= wr_val;
  end
endmodule

// File: rtl/ftc_pin_sel.sv
module ftc_pin_sel #(
  parameter int unsigned WDOG_W = ftc_pkg::WDOG_W_DEF
) (
  input  logic              osc_stop,
  input  logic              ft_bit,
  input  logic              alarm_int_en,
  input  logic              alarm_flag,
  input  logic [WDOG_W-1:0] wdog_cfg,
  input  logic              wdog_timeout,
  input  logic              power_fail,
  input  logic              tone_sq,
  output logic              drive_low,
  output logic              test_on
);
  import ftc_pkg::*;

  ftc_qual_t qual;
  logic      steer;
  logic      irq_req;

  assign steer = wdog_cfg[WDOG_W-1];

  always_comb begin
    qual.osc_run     = ~osc_stop;
    qual.ft_on       = ft_bit;
    qual.alarm_quiet = ~alarm_int_en;
    qual.wdog_ok     = steer | (wdog_cfg == '0);
    qual.supply_ok   = ~power_fail;
  end

  assign test_on = qual_all(qual);
  assign irq_req = (alarm_int_en & alarm_flag) | (wdog_timeout & ~steer);

  always_comb begin
    if (power_fail)   drive_low = 1'b0;
    else if (test_on) drive_low = ~tone_sq;
    else              drive_low = irq_req;
  end
endmodule

// File: rtl/ftc_top.sv
module ftc_top #(
  parameter int unsigned TONE_HALF = ftc_pkg::TONE_HALF_DEF,
  parameter int unsigned WDOG_W    = ftc_pkg::WDOG_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              osc_stop,
  input  logic              ft_wr_en,
  input  logic              ft_wr_val,
  input  logic              alarm_int_en,
  input  logic              alarm_flag,
  input  logic [WDOG_W-1:0] wdog_cfg,
  input  logic              wdog_timeout,
  input  logic              power_fail,
  output logic              pin_drive_low,
  output logic              ft_bit,
  output logic              tone_active
);
  logic tone_sq;
  logic div_en;

  assign div_en = osc_tick & ~osc_stop;

  ftc_tone_div #(.TONE_HALF(TONE_HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (div_en),
    .sq      (tone_sq)
  );

  ftc_ft_reg u_ft (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ft_wr_en),
    .wr_val     (ft_wr_val),
    .power_fail (power_fail),
    .ft_q       (ft_bit)
  );

  ftc_pin_sel #(.WDOG_W(WDOG_W)) u_sel (
    .osc_stop     (osc_stop),
    .ft_bit       (ft_bit),
    .alarm_int_en (alarm_int_en),
    .alarm_flag   (alarm_flag),
    .wdog_cfg     (wdog_cfg),
    .wdog_timeout (wdog_timeout),
    .power_fail   (power_fail),
    .tone_sq      (tone_sq),
    .drive_low    (pin_drive_low),
    .test_on      (tone_active)
  );
endmodule

// File: rtl/ftc_chk.sv
module ftc_chk #(
  parameter int unsigned WDOG_W = ftc_pkg::WDOG_W_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_tick,
  input logic              osc_stop,
  input logic              ft_wr_en,
  input logic              ft_wr_val,
  input logic              alarm_int_en,
  input logic              alarm_flag,
  input logic [WDOG_W-1:0] wdog_cfg,
  input logic              wdog_timeout,
  input logic              power_fail,
  input logic              pin_drive_low,
  input logic              ft_bit,
  input logic              tone_sq
);
  logic cond;
  logic irq;
  assign cond = !osc_stop && ft_bit && !alarm_int_en && !power_fail &&
                (wdog_cfg[WDOG_W-1] || (wdog_cfg == '0));
  assign irq  = (alarm_int_en && alarm_flag) || (wdog_timeout && !wdog_cfg[WDOG_W-1]);

  // R3
  pf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_fail |-> !pin_drive_low);
  // R3
  pf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_fail |=> !ft_bit);
  // R2
  ft_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ft_wr_en && !power_fail) |=> (ft_bit == $past(ft_wr_val)));
  // R6
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> $stable(tone_sq));
  // R5
  flip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tone_sq) |-> $past(osc_tick && !osc_stop));
  // R5
  tone_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond |-> (pin_drive_low == !tone_sq));
  // R7
  irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cond && !power_fail) |-> (pin_drive_low == irq));
endmodule

bind ftc_top ftc_chk #(.WDOG_W(WDOG_W)) u_chk (.*);

// File: tb/ftc_top_test.sv
`timescale 1ns/1ps
module ftc_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0, osc_stop = 1'b0;
  logic       ft_wr_en = 1'b0, ft_wr_val = 1'b0;
  logic       alarm_int_en = 1'b0, alarm_flag = 1'b0;
  logic [7:0] wdog_cfg = 8'h00;
  logic       wdog_timeout = 1'b0, power_fail = 1'b0;
  logic       pin_drive_low, ft_bit, tone_active;

  int n_chk = 0;
  int n_fail = 0;
  int ticks = 0;   // ticks counted while the oscillator runs
  bit done = 0;

  always #2 clk = ~clk;

  ftc_top uut (.*);

  // vector: [15:14] mode (0 released, 1 low, 2 tone), [13] stop, [12] ft,
  // [11] alarm en, [10] alarm flag, [9] wdog timeout, [8] power fail, [7:0] wdog cfg
  localparam logic [15:0] VEC [9] = '{
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h8E},
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0E},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0E},
    {2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h8E},
    {2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0E}
  };

  function automatic logic phase_low();
    return ((ticks / 32) % 2) == 0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_tick = 1'b1;
      @(negedge clk) osc_tick = 1'b0;
      if (!osc_stop) ticks++;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic write_ft(input logic v);
    @(negedge clk) begin ft_wr_en = 1'b1; ft_wr_val = v; end
    @(negedge clk) ft_wr_en = 1'b0;
  endtask

  task automatic check_mode(input string req, input logic [1:0] mode);
    logic exp;
    exp = (mode == 2'd2) ? phase_low() : (mode == 2'd1);
    check(req, pin_drive_low, exp);
    check("R4 tone_active", tone_active, mode == 2'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin", pin_drive_low, 1'b0);
    check("R1 ft", ft_bit, 1'b0);

    // R2 write and clear
    write_ft(1'b1);
    check("R2 write 1", ft_bit, 1'b1);
    write_ft(1'b0);
    check("R2 write 0", ft_bit, 1'b0);

    // R8: divider runs outside test mode (40 ticks -> phase high)
    tick_n(40);

    // table walk (R4, R5, R7)
    for (int v = 0; v < 9; v++) begin
      power_fail = 1'b0;
      write_ft(VEC[v][12]);
      @(negedge clk) begin
        osc_stop     = VEC[v][13];
        alarm_int_en = VEC[v][11];
        alarm_flag   = VEC[v][10];
        wdog_timeout = VEC[v][9];
        power_fail   = VEC[v][8];
        wdog_cfg     = VEC[v][7:0];
      end
      @(negedge clk);
      check_mode(v == 0 ? "R8 phase carried" : "R4/R7 mode", VEC[v][15:14]);
      tick_n(32);
      check_mode("R5 after 32 ticks", VEC[v][15:14]);
    end
    // R3: last vector had power fail asserted
    check("R3 ft cleared", ft_bit, 1'b0);
    power_fail = 1'b0; alarm_int_en = 1'b0; alarm_flag = 1'b0;
    wdog_timeout = 1'b0; wdog_cfg = 8'h00; osc_stop = 1'b0;

    // R3: power fail wins over a write in the same cycle
    @(negedge clk) begin ft_wr_en = 1'b1; ft_wr_val = 1'b1; power_fail = 1'b1; end
    @(negedge clk) begin ft_wr_en = 1'b0; power_fail = 1'b0; end
    check("R3 pf beats write", ft_bit, 1'b0);

    // R5: exact half period of 32 ticks
    write_ft(1'b1);
    tick_n(32 - (ticks % 32) - 1);
    check_mode("R5 before edge", 2'd2);
    tick_n(1);
    check_mode("R5 at edge", 2'd2);

    // R6: stopped oscillator freezes the phase
    begin
      logic held;
      held = pin_drive_low;
      osc_stop = 1'b1;
      tick_n(48);
      osc_stop = 1'b0;
      @(negedge clk);
      check("R6 frozen", pin_drive_low, held);
      check_mode("R6 resume", 2'd2);
    end

    // R3: power fail releases the pin even with an interrupt pending
    write_ft(1'b0);
    @(negedge clk) begin alarm_int_en = 1'b1; alarm_flag = 1'b1; end
    @(negedge clk);
    check("R7 alarm low", pin_drive_low, 1'b1);
    power_fail = 1'b1;
    @(negedge clk);
    check("R3 released", pin_drive_low, 1'b0);
    power_fail = 1'b0;

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule